// File: doc/BRIEF.md
# Switchable-Width Serial Frame Check Unit

This block computes a frame check sequence one bit at a time. One instance serves both directions of a serial link. When sending, it divides the frame body and then emits the complemented remainder on a serial output. When receiving, it divides everything it is fed, check field included, and flags a good frame when the register ends at a fixed residue.

A static select input chooses between two polynomials. In the narrow mode the polynomial is x^16 + x^12 + x^5 + 1. In the wide mode it is the 32-bit polynomial x^32+x^26+x^23+x^22+x^16+x^12+x^11+x^10+x^8+x^7+x^5+x^4+x^2+x+1.

Data enters low-order bit first, and the register runs in reflected form. A clear input starts each frame. A bit strobe qualifies the data bit. A mode input decides whether a strobe divides the bit or emits one bit of the complemented remainder. Bit stuffing, flag handling and byte assembly belong to the surrounding logic.

Top module: `fcs_unit`

## Requirements
- R1: Reset, or `fcs_clear` high at a clock edge, loads the register with all ones, so `fcs_out` reads 0 on the next cycle. `fcs_clear` takes priority over `bit_stb`.
- R2: With `wide_sel`=0, dividing the ASCII bytes "123456789" (each byte low bit first) leaves `fcs_out` = 0x0000906E.
- R3: With `wide_sel`=1, the same nine bytes leave `fcs_out` = 0xCBF43926.
- R4: `fcs_out` is the bitwise complement of the register, limited to the active width. Bits 31:16 read 0 while `wide_sel`=0.
- R5: In a cycle with `bit_stb` and `fcs_clear` both low, the register is unchanged, whatever `bit_val` or `emit_mode` are.
- R6: When `emit_mode`=1, each `bit_stb` moves `fcs_out` right by one place and does no division. `bit_val` is ignored, and `ser_out` always equals `fcs_out[0]`. The emitted bit sequence is therefore the check value, low-order bit first.
- R7: `emit_done` rises after exactly 16 (narrow) or 32 (wide) emit strobes counted since the last clear or dividing strobe. It is cleared by `fcs_clear` or by a dividing strobe.
- R8: `good_frame` is 1 exactly when the register holds the residue, which is 0xF0B8 in the narrow mode and 0xDEBB20E3 in the wide mode. This happens after an intact frame followed by its emitted check bits. A single flipped bit leaves `good_frame` at 0.
- R9: `wide_sel` changes only in a cycle in which `fcs_clear` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fcs_clear | input | 1 | Start of frame: preset the register to all ones |
| wide_sel | input | 1 | 0 selects the 16-bit polynomial, 1 selects the 32-bit polynomial |
| bit_stb | input | 1 | Bit strobe: one division step or one emit step |
| bit_val | input | 1 | Serial data bit, used when dividing |
| emit_mode | input | 1 | 1: a strobe shifts out the check value; 0: a strobe divides `bit_val` |
| fcs_out | output | 32 | Complemented remainder, masked to the active width |
| ser_out | output | 1 | Next check bit to send (low bit of `fcs_out`) |
| emit_done | output | 1 | The full check value has been emitted |
| good_frame | output | 1 | The register equals the good-frame residue |

## Verification
The assertions assume that the width select is static during a frame: it may change only in the same cycle as a clear. The stimulus moves `wide_sel` only together with `fcs_clear`. The assertions also assume that a clear and a strobe in the same cycle resolve in favour of the clear. The bench issues one such collision on purpose to check that priority. Outside those points, strobes, emit mode and data bits are driven freely, including idle cycles that toggle `bit_val` and `emit_mode` with no strobe.

// File: rtl/fcs_pkg.sv
package fcs_pkg;
  localparam int FCS_W_WIDE   = 32;
  localparam int FCS_W_NARROW = 16;
  // Reflected polynomial constants (bit 0 holds the highest power term).
  localparam logic [31:0] POLY_NARROW_REFL = 32'h0000_8408;
  localparam logic [31:0] POLY_WIDE_REFL   = 32'hEDB8_8320;
  localparam logic [31:0] RESIDUE_NARROW   = 32'h0000_F0B8;
  localparam logic [31:0] RESIDUE_WIDE     = 32'hDEBB_20E3;

  function automatic logic [31:0] width_mask(input logic wide);
    return wide ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction
endpackage

// File: rtl/fcs_lfsr.sv
module fcs_lfsr #(
  parameter int W       = 32,
  parameter int WN      = 16,
  parameter logic [W-1:0] POLY_N = '0,
  parameter logic [W-1:0] POLY_W = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         sel_wide,
  input  logic         strobe,
  input  logic         shift_mode,
  input  logic         din,
  output logic [W-1:0] state_q
);
  logic [W-1:0] shifted;
  logic [W-1:0] state_d;
  logic         fill;
  logic         fb;

  always_comb begin
    fill = shift_mode;
    fb   = state_q[0] ^ din;
    if (sel_wide) shifted = {fill, state_q[W-1:1]};
    else          shifted = {state_q[W-1:WN], fill, state_q[WN-1:1]};
    state_d = state_q;
    if (strobe) begin
      state_d = shifted;
      if (!shift_mode && fb) state_d = shifted ^ (sel_wide ? POLY_W : POLY_N);
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clear) state_q <= '1;
    else              state_q <= state_d;
  end

  // R1
  clear_preset_chk: assert property (@(posedge clk) disable iff (rst)
    clear |=> (state_q == '1));

  // R5
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clear && !strobe) |=> $stable(state_q));
endmodule

// File: rtl/fcs_shift_cnt.sv
module fcs_shift_cnt #(
  parameter int CW = 6
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          strobe,
  input  logic          shift_mode,
  input  logic [CW-1:0] limit,
  output logic          done
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear) cnt_q <= '0;
    else if (strobe) begin
      if (!shift_mode)         cnt_q <= '0;
      else if (cnt_q != limit) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done = (cnt_q == limit);

  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(strobe && shift_mode && !clear));

  // R7
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (strobe && !shift_mode) |=> !done);
endmodule

// File: rtl/fcs_residue_cmp.sv
module fcs_residue_cmp #(
  parameter int W  = 32,
  parameter int WN = 16,
  parameter logic [W-1:0] RES_N = '0,
  parameter logic [W-1:0] RES_W = '0
) (
  input  logic [W-1:0] state,
  input  logic         sel_wide,
  output logic         match
);
  always_comb begin
    if (sel_wide) match = (state == RES_W);
    else          match = (state[WN-1:0] == RES_N[WN-1:0]);
  end
endmodule

// File: rtl/fcs_unit.sv
module fcs_unit
  import fcs_pkg::*;
#(
  parameter int W_WIDE   = FCS_W_WIDE,
  parameter int W_NARROW = FCS_W_NARROW,
  parameter logic [W_WIDE-1:0] POLY_N = POLY_NARROW_REFL,
  parameter logic [W_WIDE-1:0] POLY_W = POLY_WIDE_REFL,
  parameter logic [W_WIDE-1:0] RES_N  = RESIDUE_NARROW,
  parameter logic [W_WIDE-1:0] RES_W  = RESIDUE_WIDE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              fcs_clear,
  input  logic              wide_sel,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              emit_mode,
  output logic [W_WIDE-1:0] fcs_out,
  output logic              ser_out,
  output logic              emit_done,
  output logic              good_frame
);
  localparam int CW = $clog2(W_WIDE + 1);
  localparam logic [W_WIDE-1:0] NARROW_MASK = {{(W_WIDE-W_NARROW){1'b0}}, {W_NARROW{1'b1}}};

  logic [W_WIDE-1:0] state;
  logic [CW-1:0]     limit;

  fcs_lfsr #(.W(W_WIDE), .WN(W_NARROW), .POLY_N(POLY_N), .POLY_W(POLY_W)) u_lfsr (
    .clk(clk), .rst(rst), .clear(fcs_clear), .sel_wide(wide_sel),
    .strobe(bit_stb), .shift_mode(emit_mode), .din(bit_val), .state_q(state)
  );

  assign limit = wide_sel ? CW'(W_WIDE) : CW'(W_NARROW);

  fcs_shift_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst(rst), .clear(fcs_clear), .strobe(bit_stb),
    .shift_mode(emit_mode), .limit(limit), .done(emit_done)
  );

  fcs_residue_cmp #(.W(W_WIDE), .WN(W_NARROW), .RES_N(RES_N), .RES_W(RES_W)) u_cmp (
    .state(state), .sel_wide(wide_sel), .match(good_frame)
  );

  assign fcs_out = ~state & (wide_sel ? '1 : NARROW_MASK);
  assign ser_out = fcs_out[0];

  // R9
  sel_static_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(wide_sel) |-> fcs_clear);

  // R6
  emit_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_stb && emit_mode && !fcs_clear) |=> (fcs_out == ($past(fcs_out) >> 1)));
endmodule

// File: tb/sim_fcs_unit.sv
module sim_fcs_unit;
  logic clk = 0, rst = 1, fcs_clear = 0, wide_sel = 0;
  logic bit_stb = 0, bit_val = 0, emit_mode = 0;
  logic [31:0] fcs_out;
  logic ser_out, emit_done, good_frame;

  int checks = 0, failures = 0;
  logic [31:0] m_reg = 32'hFFFF_FFFF;
  int m_cnt = 0;
  logic [31:0] cap;

  always #4 clk = ~clk;

  fcs_unit u0 (.clk(clk), .rst(rst), .fcs_clear(fcs_clear), .wide_sel(wide_sel),
    .bit_stb(bit_stb), .bit_val(bit_val), .emit_mode(emit_mode), .fcs_out(fcs_out),
    .ser_out(ser_out), .emit_done(emit_done), .good_frame(good_frame));

  // Behavioural reference, updated on each edge from the driven inputs.
  always @(posedge clk) begin
    int lim;
    lim = wide_sel ? 32 : 16;
    if (rst || fcs_clear) begin
      m_reg = 32'hFFFF_FFFF; m_cnt = 0;
    end else if (bit_stb) begin
      if (emit_mode) begin
        if (wide_sel) m_reg = {1'b1, m_reg[31:1]};
        else m_reg = {m_reg[31:16], 1'b1, m_reg[15:1]};
        if (m_cnt < lim) m_cnt++;
      end else begin
        if (wide_sel) begin
          if (m_reg[0] ^ bit_val) m_reg = (m_reg >> 1) ^ 32'hEDB88320;
          else m_reg = m_reg >> 1;
        end else begin
          logic [15:0] r;
          r = m_reg[15:0];
          if (r[0] ^ bit_val) r = (r >> 1) ^ 16'h8408;
          else r = r >> 1;
          m_reg = {m_reg[31:16], r};
        end
        m_cnt = 0;
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic compare_model();
    logic [31:0] eo;
    eo = ~m_reg & (wide_sel ? 32'hFFFF_FFFF : 32'h0000_FFFF);
    chk("R4 fcs_out vs model", fcs_out, eo);
    chk("R6 ser_out vs model", {31'd0, ser_out}, {31'd0, eo[0]});
    chk("R7 emit_done vs model", {31'd0, emit_done}, {31'd0, m_cnt == (wide_sel ? 32 : 16)});
    chk("R8 good_frame vs model", {31'd0, good_frame},
        {31'd0, wide_sel ? (m_reg == 32'hDEBB20E3) : (m_reg[15:0] == 16'hF0B8)});
  endtask

  task automatic cyc(logic c, logic s, logic e, logic b);
    fcs_clear = c; bit_stb = s; emit_mode = e; bit_val = b;
    @(negedge clk);
    compare_model();
  endtask

  task automatic send_byte(logic [7:0] v);
    for (int i = 0; i < 8; i++) cyc(0, 1, 0, v[i]);
  endtask

  task automatic send_digits(int flip);
    for (int k = 0; k < 9; k++) begin
      logic [7:0] v;
      v = 8'h31 + 8'(k);
      if (k == flip) v = v ^ 8'h04;
      send_byte(v);
    end
  endtask

  task automatic emit_bits(int n, logic junk);
    cap = 0;
    for (int i = 0; i < n; i++) begin
      cap[i] = ser_out;
      cyc(0, 1, 1, junk ^ i[0]);
    end
  endtask

  task automatic feed_cap(int n);
    for (int i = 0; i < n; i++) cyc(0, 1, 0, cap[i]);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1; @(negedge clk);
    // R1 reset state
    chk("R1 reset fcs_out", fcs_out, 32'h0);
    chk("R8 reset good_frame", {31'd0, good_frame}, 32'd0);
    rst = 0;
    cyc(1, 0, 0, 0);
    // R2 narrow check value
    send_digits(-1);
    chk("R2 narrow check value", fcs_out, 32'h0000_906E);
    chk("R4 narrow upper zero", {16'd0, fcs_out[31:16]}, 32'd0);
    // R5 idle cycles do nothing
    for (int i = 0; i < 6; i++) cyc(0, 0, i[0], i[1]);
    chk("R5 idle hold", fcs_out, 32'h0000_906E);
    // R6/R7 emit, with bit_val toggling (ignored)
    emit_bits(15, 1);
    chk("R7 not done after 15", {31'd0, emit_done}, 32'd0);
    cap[15] = ser_out; cyc(0, 1, 1, 0);
    chk("R6 narrow emitted bits", cap, 32'h0000_906E);
    chk("R7 done after 16", {31'd0, emit_done}, 32'd1);
    chk("R6 fully emitted", fcs_out, 32'd0);
    cyc(0, 1, 0, 1);
    chk("R7 dividing strobe clears done", {31'd0, emit_done}, 32'd0);
    // R8 narrow good frame
    cap = 32'h0000_906E;
    cyc(1, 0, 0, 0); send_digits(-1); feed_cap(16);
    chk("R8 narrow good frame", {31'd0, good_frame}, 32'd1);
    cyc(1, 0, 0, 0); send_digits(4); feed_cap(16);
    chk("R8 narrow corrupt frame", {31'd0, good_frame}, 32'd0);
    // R3 wide mode, width changes only with clear (R9)
    wide_sel = 1; cyc(1, 0, 0, 0);
    send_digits(-1);
    chk("R3 wide check value", fcs_out, 32'hCBF4_3926);
    emit_bits(32, 0);
    chk("R6 wide emitted bits", cap, 32'hCBF4_3926);
    chk("R7 wide done after 32", {31'd0, emit_done}, 32'd1);
    cyc(1, 0, 0, 0); send_digits(-1); feed_cap(32);
    chk("R8 wide good frame", {31'd0, good_frame}, 32'd1);
    cyc(1, 0, 0, 0); send_digits(0); feed_cap(32);
    chk("R8 wide corrupt frame", {31'd0, good_frame}, 32'd0);
    // R1 clear beats strobe
    cyc(0, 1, 0, 1);
    cyc(1, 1, 0, 1);
    chk("R1 clear priority", fcs_out, 32'd0);
    wide_sel = 0; cyc(1, 0, 0, 0);
    chk("R4 narrow after switch", fcs_out, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule